// File: doc/BRIEF.md
# SD Card SPI-Mode Block Write Engine

This block carries the data phase of a single-block or multi-block write to a memory card in SPI mode. Once the write command has been accepted, the controller pulses `start` with a block count, a block size and a multi-block flag. For every block the engine sends a filler byte, a start token, the payload pulled from a valid/ready byte stream, and a CRC16 over that payload. It then searches the card's replies for the data-response token and polls until the card stops signalling busy.

Every byte goes through a byte-exchange port toward an SPI shifter. The engine raises a request with a transmit byte, and the shifter acknowledges it for one cycle with the byte received in that same exchange. In multi-block mode a clean run ends with a stop token and one more busy poll. The run finishes with a one-cycle `done` pulse, which comes with either a reject error or a timeout error when the run failed.

Top module: `sd_spi_block_writer`

## Requirements
- R1: After reset, `xch_req`, `pay_ready`, `done`, `err_reject`, `err_timeout` and `active` are all low.
- R2: Each block starts with a byte 0xFF and then a start token. The token is 0xFE when `multi` was low at start and 0xFC when it was high. The `blk_size` payload bytes (1 or more) follow in the order they were accepted.
- R3: After the payload come two bytes: high byte first, then low byte, of a CRC16 over that block's payload. The CRC uses polynomial 0x1021 and starts from zero, with each byte entered most significant bit first.
- R4: A payload byte is taken only in a cycle where `pay_valid` and `pay_ready` are both high. `pay_ready` is never high while an exchange is pending, and a low `pay_valid` stalls the block without losing or repeating any byte.
- R5: After the CRC the engine reads up to 8 bytes, sending 0xFF each time. The first byte read with bit 4 clear is the data-response token. If none of the 8 has bit 4 clear, the run ends with `err_reject`.
- R6: The token is accepted only when its bits [4:0] equal 5'b00101, whatever its upper bits hold. Any other value ends the run at once with `err_reject`, with no further exchange and no stop token.
- R7: After an accepted token, the engine polls by sending 0xFF. The first polled byte is disregarded even when it is 0xFF. The poll ends at the first later byte equal to 0xFF. If no such byte arrives within POLL_MAX polled bytes, the run ends with `err_timeout`.
- R8: In multi-block mode, once every block has finished without error, the engine sends 0xFF and then 0xFD and runs the same bounded poll as R7. In single-block mode the run ends after the last block's poll.
- R9: While `xch_req` is high and `xch_ack` is low, `xch_req` stays high and `xch_tx` holds its value. `xch_req` is low in the cycle after an acknowledge.
- R10: `done` is a single-cycle pulse. `err_reject` and `err_timeout` are never high together, change only together with `done` or just after an accepted `start`, and hold their value until the next run.
- R11: A start with `blk_count` equal to zero gives `done` one cycle later with no errors and no exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only while idle |
| blk_count | input | CNT_W | Number of blocks to write |
| blk_size | input | SIZE_W | Payload bytes per block |
| multi | input | 1 | Multi-block mode selection |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Engine takes the payload byte this cycle if valid |
| xch_req | output | 1 | Byte exchange requested |
| xch_tx | output | 8 | Byte to send in the exchange |
| xch_ack | input | 1 | Exchange complete (one cycle) |
| xch_rx | input | 8 | Byte received in the completed exchange |
| active | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| err_reject | output | 1 | Run ended on a missing or non-accepted token |
| err_timeout | output | 1 | Run ended on an expired busy poll |

## Verification
The hardest cases to reach from the ports are those where the card's reply decides the outcome. These are a token that turns up only after several filler bytes, a token never arriving within the eight-read window, a first busy byte of 0xFF that must be ignored, and a busy phase that ends exactly on the last allowed poll or never ends at all. The bench uses a scripted card model that parses the outgoing stream and can be set to answer with a given reply delay, token, first busy byte and busy length. Every one of those points is then reached by choosing the card settings for each run. The poll bound is made small so that the timeout case is short to run.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FILL, S_TOKEN, S_PAY, S_CRC_HI, S_CRC_LO,
    S_RESP, S_POLL, S_STOP_FILL, S_STOP_TOK, S_STOP_POLL
  } sdw_state_e;

  localparam logic [7:0] FILLER_BYTE  = 8'hFF;
  localparam logic [7:0] TOK_SINGLE   = 8'hFE;
  localparam logic [7:0] TOK_MULTI    = 8'hFC;
  localparam logic [7:0] TOK_STOP     = 8'hFD;
  localparam logic [4:0] RESP_ACCEPT  = 5'b00101;
  localparam logic [15:0] CRC_POLY    = 16'h1021;

  // CRC16 step over one byte, MSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int k = 0; k < 8; k++) begin
      r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/sdw_crc16_acc.sv
module sdw_crc16_acc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  import sdw_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= 16'h0000;
    else if (en)       crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/sdw_bound_ctr.sv
module sdw_bound_ctr #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic at_first,
  output logic at_last
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign at_first = (cnt == '0);
  assign at_last  = (cnt == W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)        cnt <= '0;
    else if (step && !at_last) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sd_spi_block_writer.sv
module sd_spi_block_writer #(
  parameter int SIZE_W     = 10,
  parameter int CNT_W      = 8,
  parameter int POLL_MAX   = 65536,
  parameter int RESP_TRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  blk_count,
  input  logic [SIZE_W-1:0] blk_size,
  input  logic              multi,
  input  logic [7:0]        pay_data,
  input  logic              pay_valid,
  output logic              pay_ready,
  output logic              xch_req,
  output logic [7:0]        xch_tx,
  input  logic              xch_ack,
  input  logic [7:0]        xch_rx,
  output logic              active,
  output logic              done,
  output logic              err_reject,
  output logic              err_timeout
);
  import sdw_pkg::*;

  sdw_state_e        st;
  logic              req_q;
  logic [7:0]        txb;
  logic [CNT_W-1:0]  blk_left;
  logic [SIZE_W-1:0] size_q, byte_left;
  logic              multi_q, done_q, erj_q, eto_q;
  logic [15:0]       crc_val;
  logic [7:0]        tx_next;
  logic              poll_first, poll_last, resp_last;

  // Named internal events, also used by the checker.
  logic xfer_ok, pay_hs, auto_issue, issue, in_poll;
  logic resp_found, ev_accept, ev_reject, ev_ready, ev_timeout;

  assign xfer_ok    = req_q && xch_ack;
  assign pay_ready  = (st == S_PAY) && !req_q;
  assign pay_hs     = pay_ready && pay_valid;
  assign in_poll    = (st == S_POLL) || (st == S_STOP_POLL);
  assign auto_issue = !req_q && (st != S_IDLE) && (st != S_PAY);
  assign issue      = auto_issue || pay_hs;

  assign resp_found = xfer_ok && (st == S_RESP) && !xch_rx[4];
  assign ev_accept  = resp_found && (xch_rx[4:0] == RESP_ACCEPT);
  assign ev_reject  = (resp_found && !ev_accept) ||
                      (xfer_ok && (st == S_RESP) && xch_rx[4] && resp_last);
  assign ev_ready   = xfer_ok && in_poll && !poll_first && (xch_rx == FILLER_BYTE);
  assign ev_timeout = xfer_ok && in_poll && !ev_ready && poll_last;

  always_comb begin
    unique case (st)
      S_TOKEN:    tx_next = multi_q ? TOK_MULTI : TOK_SINGLE;
      S_PAY:      tx_next = pay_data;
      S_CRC_HI:   tx_next = crc_val[15:8];
      S_CRC_LO:   tx_next = crc_val[7:0];
      S_STOP_TOK: tx_next = TOK_STOP;
      default:    tx_next = FILLER_BYTE;
    endcase
  end

  sdw_crc16_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(st == S_TOKEN), .en(pay_hs),
    .din(pay_data), .crc(crc_val)
  );

  sdw_bound_ctr #(.LIMIT(POLL_MAX)) u_poll_ctr (
    .clk(clk), .rst_n(rst_n), .clr(!in_poll), .step(xfer_ok),
    .at_first(poll_first), .at_last(poll_last)
  );

  logic resp_first_unused;
  sdw_bound_ctr #(.LIMIT(RESP_TRIES)) u_resp_ctr (
    .clk(clk), .rst_n(rst_n), .clr(st != S_RESP), .step(xfer_ok),
    .at_first(resp_first_unused), .at_last(resp_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      req_q     <= 1'b0;
      txb       <= FILLER_BYTE;
      blk_left  <= '0;
      size_q    <= '0;
      byte_left <= '0;
      multi_q   <= 1'b0;
      done_q    <= 1'b0;
      erj_q     <= 1'b0;
      eto_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (issue) begin
        req_q <= 1'b1;
        txb   <= tx_next;
      end else if (xfer_ok) begin
        req_q <= 1'b0;
      end

      unique case (st)
        S_IDLE: if (start) begin
          erj_q <= 1'b0;
          eto_q <= 1'b0;
          if (blk_count == '0) done_q <= 1'b1;
          else begin
            blk_left <= blk_count;
            size_q   <= blk_size;
            multi_q  <= multi;
            st       <= S_FILL;
          end
        end
        S_FILL:  if (xfer_ok) st <= S_TOKEN;
        S_TOKEN: if (xfer_ok) begin
          byte_left <= size_q;
          st        <= S_PAY;
        end
        S_PAY: if (xfer_ok) begin
          byte_left <= byte_left - 1'b1;
          if (byte_left == SIZE_W'(1)) st <= S_CRC_HI;
        end
        S_CRC_HI: if (xfer_ok) st <= S_CRC_LO;
        S_CRC_LO: if (xfer_ok) st <= S_RESP;
        S_RESP: begin
          if (ev_accept) st <= S_POLL;
          else if (ev_reject) begin
            erj_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_POLL: begin
          if (ev_ready) begin
            if (blk_left > CNT_W'(1)) begin
              blk_left <= blk_left - 1'b1;
              st       <= S_FILL;
            end else if (multi_q) st <= S_STOP_FILL;
            else begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
          end else if (ev_timeout) begin
            eto_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_STOP_FILL: if (xfer_ok) st <= S_STOP_TOK;
        S_STOP_TOK:  if (xfer_ok) st <= S_STOP_POLL;
        S_STOP_POLL: begin
          if (ev_ready) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else if (ev_timeout) begin
            eto_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign xch_req     = req_q;
  assign xch_tx      = txb;
  assign active      = (st != S_IDLE);
  assign done        = done_q;
  assign err_reject  = erj_q;
  assign err_timeout = eto_q;
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic       err_reject,
  input logic       err_timeout,
  input logic       xch_req,
  input logic       xch_ack,
  input logic [7:0] xch_tx,
  input logic       pay_ready,
  input logic       active,
  input logic       ev_reject,
  input logic       ev_timeout
);
  assert_tx_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_req && !xch_ack) |=> (xch_req && $stable(xch_tx)));

  assert_req_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xch_req && xch_ack) |=> !xch_req);

  assert_ready_no_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> !xch_req);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_single_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_reject && err_timeout));

  assert_error_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (done || ($stable(err_reject) && $stable(err_timeout))));

  assert_reject_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_reject |=> (done && err_reject && !active));

  assert_timeout_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (done && err_timeout && !active));
endmodule

bind sd_spi_block_writer sdw_checker u_sdw_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .err_reject(err_reject), .err_timeout(err_timeout),
  .xch_req(xch_req), .xch_ack(xch_ack), .xch_tx(xch_tx),
  .pay_ready(pay_ready), .active(active),
  .ev_reject(ev_reject), .ev_timeout(ev_timeout)
);

// File: tb/sd_spi_block_writer_tb_top.sv
module sd_spi_block_writer_tb_top;
  localparam int SIZE_W = 10;
  localparam int CNT_W  = 8;
  localparam int POLL   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0]  blk_count = '0;
  logic [SIZE_W-1:0] blk_size = '0;
  logic multi = 1'b0;
  logic [7:0] pay_data = 8'h00;
  logic pay_valid = 1'b0;
  logic pay_ready, xch_req, active, done, err_reject, err_timeout;
  logic [7:0] xch_tx;
  logic xch_ack = 1'b0;
  logic [7:0] xch_rx = 8'hFF;

  always #5 clk = ~clk;

  sd_spi_block_writer #(.SIZE_W(SIZE_W), .CNT_W(CNT_W), .POLL_MAX(POLL), .RESP_TRIES(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count), .blk_size(blk_size),
    .multi(multi), .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .xch_req(xch_req), .xch_tx(xch_tx), .xch_ack(xch_ack), .xch_rx(xch_rx),
    .active(active), .done(done), .err_reject(err_reject), .err_timeout(err_timeout)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Scoreboard queue of expected outgoing bytes, payload source queue.
  logic [7:0] exp_q[$];
  logic [7:0] pay_q[$];

  // Card model configuration and state.
  int cfg_size, cfg_delay, cfg_zeros;
  logic [7:0] cfg_token, cfg_first;
  int cst = 0;
  int ccnt = 0;

  // Card model / monitor: acknowledges each request and pops the scoreboard.
  always @(posedge clk) begin
    if (!rst_n) begin
      xch_ack <= 1'b0;
    end else begin
      xch_ack <= 1'b0;
      if (xch_req && !xch_ack) begin
        logic [7:0] r;
        xch_ack <= 1'b1;
        if (exp_q.size() == 0) chk(1'b0, "R2/R5/R7/R8 extra exchange", int'(xch_tx), -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(xch_tx == e, "R2/R3/R5/R7/R8 byte stream", int'(xch_tx), int'(e));
        end
        r = 8'hFF;
        case (cst)
          0: begin
            if (xch_tx == 8'hFE || xch_tx == 8'hFC) begin cst = 1; ccnt = 0; end
            else if (xch_tx == 8'hFD) begin cst = 3; ccnt = 0; end
          end
          1: begin
            ccnt++;
            if (ccnt == cfg_size + 2) begin cst = 2; ccnt = 0; end
          end
          2: begin
            if (ccnt == cfg_delay) begin r = cfg_token; cst = 3; ccnt = 0; end
            else ccnt++;
          end
          default: begin
            if (ccnt == 0) r = cfg_first;
            else if (ccnt <= cfg_zeros) r = 8'h00;
            else begin r = 8'hFF; cst = 0; end
            ccnt++;
            if (cst == 0) ccnt = 0;
          end
        endcase
        xch_rx <= r;
      end
    end
  end

  // Payload driver with optional valid gaps.
  bit gap_en = 1'b0;
  bit hs = 1'b0;
  int gap_ctr = 0;
  always @(negedge clk) begin
    if (hs) void'(pay_q.pop_front());
    gap_ctr++;
    pay_valid = (pay_q.size() > 0) && !(gap_en && (gap_ctr % 3 == 0));
    pay_data  = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
    #1 hs = pay_valid && pay_ready;
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] x = c;
    for (int k = 7; k >= 0; k--) begin
      logic fb = x[15] ^ d[k];
      x = {x[14:0], 1'b0};
      if (fb) x = x ^ 16'h1021;
    end
    return x;
  endfunction

  task automatic push_reads(input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(8'hFF);
  endtask

  task automatic run_case(input string name, input int seed, input int cnt, input int size,
                          input bit mul, input int delay, input logic [7:0] tok,
                          input logic [7:0] first, input int zeros, input bit gaps);
    int err = 0;
    int np  = (zeros + 2 > POLL) ? POLL : zeros + 2;
    for (int b = 0; b < cnt; b++) begin
      logic [15:0] c = 16'h0000;
      if (err != 0) break;
      exp_q.push_back(8'hFF);
      exp_q.push_back(mul ? 8'hFC : 8'hFE);
      for (int i = 0; i < size; i++) begin
        logic [7:0] d = 8'(((b * 37) + (i * 11) + (seed * 5)) ^ 90);
        exp_q.push_back(d);
        pay_q.push_back(d);
        c = ref_crc(c, d);
      end
      exp_q.push_back(c[15:8]);
      exp_q.push_back(c[7:0]);
      push_reads(delay >= 8 ? 8 : delay + 1);
      if (delay >= 8 || tok[4:0] != 5'b00101) begin err = 1; break; end
      push_reads(np);
      if (zeros + 2 > POLL) err = 2;
    end
    if (mul && err == 0 && cnt > 0) begin
      exp_q.push_back(8'hFF);
      exp_q.push_back(8'hFD);
      push_reads(np);
      if (zeros + 2 > POLL) err = 2;
    end
    @(negedge clk);
    cfg_size = size; cfg_delay = delay; cfg_token = tok; cfg_first = first; cfg_zeros = zeros;
    cst = 0; ccnt = 0; gap_en = gaps;
    blk_count = CNT_W'(cnt); blk_size = SIZE_W'(size); multi = mul;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    $display("case %s finished", name);
    chk(err_reject == (err == 1), "R5/R6 reject flag", int'(err_reject), int'(err == 1));
    chk(err_timeout == (err == 2), "R7 timeout flag", int'(err_timeout), int'(err == 2));
    chk(active == 1'b0, "R10 idle at done", int'(active), 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single pulse", int'(done), 0);
    chk(err_reject == (err == 1) && err_timeout == (err == 2), "R10 error held",
        int'({err_reject, err_timeout}), int'({err == 1, err == 2}));
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R8 missing exchanges", exp_q.size(), 0);
    chk(pay_q.size() == 0, "R4 payload consumed", pay_q.size(), 0);
    exp_q.delete();
    pay_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(!xch_req && !pay_ready && !done && !err_reject && !err_timeout && !active,
        "R1 reset state", int'({xch_req, pay_ready, done, err_reject, err_timeout, active}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R3 R6 R7: single block, token with upper bits set, first busy 0xFF ignored
    run_case("single", 1, 1, 4, 1'b0, 0, 8'hE5, 8'hFF, 2, 1'b0);
    // R2 R4 R5 R8: multi block, delayed token, valid gaps, stop sequence
    run_case("multi", 2, 3, 3, 1'b1, 2, 8'h05, 8'h00, 0, 1'b1);
    // R6: CRC-error token aborts without stop token
    run_case("crc_tok", 3, 2, 2, 1'b1, 1, 8'h0B, 8'h00, 0, 1'b0);
    // R5: no token within 8 reads
    run_case("no_tok", 4, 1, 2, 1'b0, 20, 8'h05, 8'h00, 0, 1'b0);
    // R7: busy never ends
    run_case("busy_to", 5, 1, 2, 1'b0, 0, 8'h05, 8'h00, 50, 1'b1);
    // R6: write-error token in multi mode
    run_case("wr_err", 6, 2, 1, 1'b1, 0, 8'h0D, 8'h00, 0, 1'b0);
    // R7 R8: ready on the last allowed poll in the stop phase too
    run_case("edge_poll", 7, 1, 5, 1'b1, 7, 8'h05, 8'hFF, POLL - 2, 1'b1);
    // R11: zero block count
    run_case("zero", 8, 0, 3, 1'b1, 0, 8'h05, 8'h00, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule